// File: doc/BRIEF.md
# Scanline Timing Event Generator

This block watches the horizontal and vertical position counters of a video-synchronous CPU system and produces single-clock strobes at the moments per-line work has to start. The strobes are HDMA table initialisation, DRAM refresh, HDMA transfer run and auto joypad poll. It also keeps a three-bit DMA alignment phase. This phase carries from one line to the next by adding each line's length in master clocks, modulo 8. The HDMA-init and refresh positions shift with that phase. The shift differs between the two chip revisions the block supports.

The surrounding system advances `hcount` one position per clock and wraps it to 0 at each new line. A line start is the first clock in which `hcount` reads 0 after holding another value. At each line start the block updates the phase, latches the new line length and computes every event position for the line. Those positions then stay fixed until the next line start. Downstream logic uses the strobes to start transfers, to stall for refresh and to begin the joypad shift. The strobes carry no payload.

Top module: `scan_event_gen`

## Requirements
- R1: `dma_phase` equals (accumulated phase + `hcount`) mod 8 at all times. It follows `hcount` in the same cycle, with no register on the `hcount` path.
- R2: At a line start, the accumulated phase becomes (accumulated phase + previously latched line length) mod 8, and then `line_len` is latched. After reset the latched length is 1364.
- R3: On a line whose `vcount` is 0 at line start, `ev_hdma_init` fires at position 20 − p when `rev2` = 0, or at 12 + p when `rev2` = 1. Here p is the accumulated phase after the R2 update. On any other line it does not fire.
- R4: `ev_refresh` fires once per line. Its position is 530 when `rev2` = 0, or 538 − p when `rev2` = 1. From reset until the first line start it is armed at 530 or 538, chosen by `rev2` during reset.
- R5: `ev_hdma_run` fires at position 1104 on a line whose `vcount` at line start is at most 224. With `overscan` = 1 the limit is 239.
- R6: When `joy_auto_en` is 1 at a line start on line 227, `ev_joy_poll` fires for that line start. With `overscan` = 1 the line is 242.
- R7: Each strobe is high for exactly one clock. That clock is the one after the cycle in which `hcount` first takes the event position on that line. Holding `hcount` at the position does not fire the strobe again.
- R8: Changes to `vcount`, `rev2`, `overscan` or `joy_auto_en` after a line start do not move or suppress that line's events.
- R9: Synchronous active-low reset clears the accumulated phase to 0, drops any armed HDMA-init, HDMA-run and joypad events, and drives all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hcount | input | HC_W (11) | Horizontal position within the line |
| vcount | input | VC_W (9) | Current line number |
| overscan | input | 1 | Extended-height frame mode |
| rev2 | input | 1 | 0 selects revision 1 timing, 1 selects revision 2 timing |
| line_len | input | LEN_W (11) | Length of the current line in master clocks |
| joy_auto_en | input | 1 | Auto joypad polling enable |
| dma_phase | output | 3 | DMA alignment phase |
| ev_hdma_init | output | 1 | HDMA initialisation strobe |
| ev_refresh | output | 1 | DRAM refresh strobe |
| ev_hdma_run | output | 1 | HDMA run strobe |
| ev_joy_poll | output | 1 | Auto joypad poll strobe |

## Verification
The checker confirms on every cycle that each strobe appears only where its position rule allows it:

- the init strobe inside its phase window;
- refresh between 530 and 538;
- HDMA run only after position 1104;
- the joypad poll only after a line start with polling enabled.

It also confirms that no strobe lasts two clocks and that the phase steps by one whenever `hcount` does. The bench scenarios cover what only a whole sequence can show:

- the exact phase-dependent positions as lengths accumulate across lines;
- the visible-line and poll-line limits in both frame modes;
- that mid-line input changes and a held `hcount` leave the events untouched;
- that a reset in mid-line discards armed events.

// File: rtl/scan_evt_pkg.sv
package scan_evt_pkg;

   localparam int unsigned PH_W      = 3;
   localparam int unsigned NUM_SLOTS = 3;

   // Slot index of each phase-tracked event
   typedef enum logic [1:0] {
      SLOT_HINIT = 2'd0,
      SLOT_REFR  = 2'd1,
      SLOT_HRUN  = 2'd2
   } slot_e;

endpackage

// File: rtl/scan_phase_track.sv
module scan_phase_track
   import scan_evt_pkg::*;
#(
   parameter int unsigned HC_W         = 11,
   parameter int unsigned LEN_W        = 11,
   parameter int unsigned RST_LINE_LEN = 1364
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic [HC_W-1:0]  hcount,
   input  logic [LEN_W-1:0] line_len,
   output logic [PH_W-1:0]  dma_phase,
   output logic [PH_W-1:0]  line_phase
);

   logic [PH_W-1:0]  acc_q;
   logic [LEN_W-1:0] len_q;

   // Phase that becomes valid once the current line start is taken
   assign line_phase = acc_q + len_q[PH_W-1:0];
   assign dma_phase  = acc_q + hcount[PH_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         len_q <= LEN_W'(RST_LINE_LEN);
      end else if (line_start) begin
         acc_q <= line_phase;
         len_q <= line_len;
      end
   end

endmodule

// File: rtl/scan_pos_calc.sv
module scan_pos_calc
   import scan_evt_pkg::*;
#(
   parameter int unsigned HC_W       = 11,
   parameter int unsigned HINIT_BASE = 12,
   parameter int unsigned REFR_BASE  = 530
) (
   input  logic [PH_W-1:0] line_phase,
   input  logic            rev2,
   output logic [HC_W-1:0] hinit_pos,
   output logic [HC_W-1:0] refr_pos,
   output logic [HC_W-1:0] refr_rst_pos
);

   localparam int unsigned ALIGN = 1 << PH_W;

   localparam logic [HC_W-1:0] HINIT_EARLY = HC_W'(HINIT_BASE);
   localparam logic [HC_W-1:0] HINIT_LATE  = HC_W'(HINIT_BASE + ALIGN);
   localparam logic [HC_W-1:0] REFR_FIXED  = HC_W'(REFR_BASE);
   localparam logic [HC_W-1:0] REFR_LATE   = HC_W'(REFR_BASE + ALIGN);

   logic [HC_W-1:0] ph_ext;
   assign ph_ext = HC_W'(line_phase);

   always_comb begin
      if (rev2) begin
         hinit_pos = HINIT_EARLY + ph_ext;
         refr_pos  = REFR_LATE - ph_ext;
      end else begin
         hinit_pos = HINIT_LATE - ph_ext;
         refr_pos  = REFR_FIXED;
      end
   end

   // Refresh position loaded at reset, before any line start
   assign refr_rst_pos = rev2 ? REFR_LATE : REFR_FIXED;

endmodule

// File: rtl/scan_event_slot.sv
module scan_event_slot #(
   parameter int unsigned HC_W    = 11,
   parameter bit          RST_ARM = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            arm_in,
   input  logic [HC_W-1:0] pos_in,
   input  logic [HC_W-1:0] rst_pos,
   input  logic            hc_new,
   input  logic [HC_W-1:0] hcount,
   output logic            strobe
);

   logic            arm_q;
   logic [HC_W-1:0] pos_q;
   logic            hit;

   assign hit = arm_q && hc_new && !load && (hcount == pos_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q  <= RST_ARM;
         pos_q  <= rst_pos;
         strobe <= 1'b0;
      end else begin
         strobe <= hit;
         if (load) begin
            arm_q <= arm_in;
            pos_q <= pos_in;
         end else if (hit) begin
            arm_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/scan_event_gen.sv
module scan_event_gen
   import scan_evt_pkg::*;
#(
   parameter int unsigned HC_W         = 11,
   parameter int unsigned VC_W         = 9,
   parameter int unsigned LEN_W        = 11,
   parameter int unsigned HINIT_BASE   = 12,
   parameter int unsigned REFR_BASE    = 530,
   parameter int unsigned HRUN_POS     = 1104,
   parameter int unsigned VIS_LAST     = 224,
   parameter int unsigned VIS_LAST_OS  = 239,
   parameter int unsigned JOY_LINE     = 227,
   parameter int unsigned JOY_LINE_OS  = 242,
   parameter int unsigned RST_LINE_LEN = 1364
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [HC_W-1:0]  hcount,
   input  logic [VC_W-1:0]  vcount,
   input  logic             overscan,
   input  logic             rev2,
   input  logic [LEN_W-1:0] line_len,
   input  logic             joy_auto_en,
   output logic [PH_W-1:0]  dma_phase,
   output logic             ev_hdma_init,
   output logic             ev_refresh,
   output logic             ev_hdma_run,
   output logic             ev_joy_poll
);

   localparam int unsigned ALIGN = 1 << PH_W;

   // Elaboration-time parameter checks
   if (REFR_BASE + ALIGN >= (1 << HC_W)) begin : g_bad_refr
      $error("refresh window does not fit the horizontal counter");
   end
   if (HRUN_POS >= (1 << HC_W)) begin : g_bad_hrun
      $error("HDMA run position does not fit the horizontal counter");
   end
   if (HINIT_BASE == 0) begin : g_bad_hinit
      $error("HDMA init position must not coincide with the line start");
   end
   if (VIS_LAST >= (1 << VC_W) || VIS_LAST_OS >= (1 << VC_W) ||
       JOY_LINE >= (1 << VC_W) || JOY_LINE_OS >= (1 << VC_W)) begin : g_bad_vc
      $error("line limits do not fit the vertical counter");
   end
   if (RST_LINE_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("reset line length does not fit the length port");
   end

   localparam logic [VC_W-1:0] VIS_N   = VC_W'(VIS_LAST);
   localparam logic [VC_W-1:0] VIS_OS  = VC_W'(VIS_LAST_OS);
   localparam logic [VC_W-1:0] JOY_N   = VC_W'(JOY_LINE);
   localparam logic [VC_W-1:0] JOY_OS  = VC_W'(JOY_LINE_OS);
   localparam logic [HC_W-1:0] HRUN_P  = HC_W'(HRUN_POS);

   // Line start detection
   logic [HC_W-1:0] hc_q;
   logic            hc_new;
   logic            line_start;

   always_ff @(posedge clk) begin
      if (!rst_n) hc_q <= '1;
      else        hc_q <= hcount;
   end

   assign hc_new     = (hcount != hc_q);
   assign line_start = hc_new && (hcount == '0);

   // Phase tracking
   logic [PH_W-1:0] line_phase;

   scan_phase_track #(
      .HC_W         (HC_W),
      .LEN_W        (LEN_W),
      .RST_LINE_LEN (RST_LINE_LEN)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .hcount     (hcount),
      .line_len   (line_len),
      .dma_phase  (dma_phase),
      .line_phase (line_phase)
   );

   // Position computation
   logic [HC_W-1:0] hinit_pos;
   logic [HC_W-1:0] refr_pos;
   logic [HC_W-1:0] refr_rst_pos;

   scan_pos_calc #(
      .HC_W       (HC_W),
      .HINIT_BASE (HINIT_BASE),
      .REFR_BASE  (REFR_BASE)
   ) u_pos (
      .line_phase   (line_phase),
      .rev2         (rev2),
      .hinit_pos    (hinit_pos),
      .refr_pos     (refr_pos),
      .refr_rst_pos (refr_rst_pos)
   );

   // Per-line arming conditions
   logic vis_line;
   logic joy_line;

   assign vis_line = (vcount <= (overscan ? VIS_OS : VIS_N));
   assign joy_line = (vcount == (overscan ? JOY_OS : JOY_N));

   logic [HC_W-1:0]      slot_pos  [NUM_SLOTS];
   logic [HC_W-1:0]      slot_rpos [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] slot_arm;
   logic [NUM_SLOTS-1:0] slot_stb;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      if (s == int'(SLOT_HINIT)) begin : g_hinit
         assign slot_arm[s]  = (vcount == '0);
         assign slot_pos[s]  = hinit_pos;
         assign slot_rpos[s] = hinit_pos;
      end else if (s == int'(SLOT_REFR)) begin : g_refr
         assign slot_arm[s]  = 1'b1;
         assign slot_pos[s]  = refr_pos;
         assign slot_rpos[s] = refr_rst_pos;
      end else begin : g_hrun
         assign slot_arm[s]  = vis_line;
         assign slot_pos[s]  = HRUN_P;
         assign slot_rpos[s] = HRUN_P;
      end

      scan_event_slot #(
         .HC_W    (HC_W),
         .RST_ARM (s == int'(SLOT_REFR))
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (line_start),
         .arm_in  (slot_arm[s]),
         .pos_in  (slot_pos[s]),
         .rst_pos (slot_rpos[s]),
         .hc_new  (hc_new),
         .hcount  (hcount),
         .strobe  (slot_stb[s])
      );
   end

   assign ev_hdma_init = slot_stb[SLOT_HINIT];
   assign ev_refresh   = slot_stb[SLOT_REFR];
   assign ev_hdma_run  = slot_stb[SLOT_HRUN];

   // Joypad poll at the start of the poll line
   logic joy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) joy_q <= 1'b0;
      else        joy_q <= line_start && joy_auto_en && joy_line;
   end

   assign ev_joy_poll = joy_q;

endmodule

// File: rtl/scan_event_gen_chk.sv
module scan_event_gen_chk #(
   parameter int unsigned HC_W       = 11,
   parameter int unsigned HINIT_BASE = 12,
   parameter int unsigned REFR_BASE  = 530,
   parameter int unsigned HRUN_POS   = 1104
) (
   input logic            clk,
   input logic            rst_n,
   input logic [HC_W-1:0] hcount,
   input logic            joy_auto_en,
   input logic [2:0]      dma_phase,
   input logic            ev_hdma_init,
   input logic            ev_refresh,
   input logic            ev_hdma_run,
   input logic            ev_joy_poll
);

   localparam logic [HC_W-1:0] HI_LO = HC_W'(HINIT_BASE);
   localparam logic [HC_W-1:0] HI_HI = HC_W'(HINIT_BASE + 8);
   localparam logic [HC_W-1:0] RF_LO = HC_W'(REFR_BASE);
   localparam logic [HC_W-1:0] RF_HI = HC_W'(REFR_BASE + 8);
   localparam logic [HC_W-1:0] HR_P  = HC_W'(HRUN_POS);

   logic [3:0] stb;
   assign stb = {ev_hdma_init, ev_refresh, ev_hdma_run, ev_joy_poll};

   p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hcount) != '0 && hcount == $past(hcount) + HC_W'(1))
      |-> dma_phase == $past(dma_phase) + 3'd1);

   p_hinit_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_hdma_init |-> ($past(hcount) >= HI_LO && $past(hcount) <= HI_HI));

   p_refresh_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_refresh |-> ($past(hcount) >= RF_LO && $past(hcount) <= RF_HI));

   p_hrun_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_hdma_run |-> $past(hcount) == HR_P);

   p_joy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_joy_poll |-> ($past(hcount) == '0 && $past(joy_auto_en)));

   p_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|stb) |=> ((stb & $past(stb)) == 4'b0));

endmodule

bind scan_event_gen scan_event_gen_chk #(
   .HC_W       (HC_W),
   .HINIT_BASE (HINIT_BASE),
   .REFR_BASE  (REFR_BASE),
   .HRUN_POS   (HRUN_POS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hcount       (hcount),
   .joy_auto_en  (joy_auto_en),
   .dma_phase    (dma_phase),
   .ev_hdma_init (ev_hdma_init),
   .ev_refresh   (ev_refresh),
   .ev_hdma_run  (ev_hdma_run),
   .ev_joy_poll  (ev_joy_poll)
);

// File: tb/scan_event_gen_tb.sv
module scan_event_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [10:0] hcount;
   logic [8:0]  vcount;
   logic        overscan;
   logic        rev2;
   logic [10:0] line_len;
   logic        joy_auto_en;
   logic [2:0]  dma_phase;
   logic        ev_hdma_init, ev_refresh, ev_hdma_run, ev_joy_poll;

   always #2 clk = ~clk;

   scan_event_gen u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .hcount       (hcount),
      .vcount       (vcount),
      .overscan     (overscan),
      .rev2         (rev2),
      .line_len     (line_len),
      .joy_auto_en  (joy_auto_en),
      .dma_phase    (dma_phase),
      .ev_hdma_init (ev_hdma_init),
      .ev_refresh   (ev_refresh),
      .ev_hdma_run  (ev_hdma_run),
      .ev_joy_poll  (ev_joy_poll)
   );

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Reference model state
   int m_acc, m_len;
   // Observation tallies
   int n_hi, p_hi, n_rf, p_rf, n_hr, p_hr, n_jp, p_jp, ph_bad;

   task automatic clear_obs();
      n_hi = 0; p_hi = -1; n_rf = 0; p_rf = -1;
      n_hr = 0; p_hr = -1; n_jp = 0; p_jp = -1; ph_bad = 0;
   endtask

   task automatic observe(input int prev);
      if (ev_hdma_init) begin n_hi++; p_hi = prev; end
      if (ev_refresh)   begin n_rf++; p_rf = prev; end
      if (ev_hdma_run)  begin n_hr++; p_hr = prev; end
      if (ev_joy_poll)  begin n_jp++; p_jp = prev; end
      if (int'(dma_phase) != ((m_acc + prev) % 8)) ph_bad++;
   endtask

   typedef struct packed {
      logic [8:0]  v;
      logic        os;
      logic        r2;
      logic [10:0] len;
      logic        joy;
      logic        flip;
      logic        stall;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{9'd0,   1'b0, 1'b0, 11'd1364, 1'b1, 1'b0, 1'b0},
      '{9'd1,   1'b0, 1'b1, 11'd1364, 1'b1, 1'b0, 1'b0},
      '{9'd0,   1'b0, 1'b1, 11'd1361, 1'b0, 1'b0, 1'b0},
      '{9'd224, 1'b0, 1'b1, 11'd1363, 1'b0, 1'b0, 1'b0},
      '{9'd225, 1'b0, 1'b0, 11'd1364, 1'b0, 1'b0, 1'b0},
      '{9'd239, 1'b1, 1'b1, 11'd1362, 1'b0, 1'b0, 1'b0},
      '{9'd227, 1'b0, 1'b0, 11'd1364, 1'b1, 1'b0, 1'b0},
      '{9'd227, 1'b0, 1'b1, 11'd1364, 1'b0, 1'b0, 1'b0},
      '{9'd242, 1'b1, 1'b0, 11'd1365, 1'b1, 1'b0, 1'b0},
      '{9'd0,   1'b0, 1'b0, 11'd1361, 1'b0, 1'b1, 1'b0},
      '{9'd10,  1'b0, 1'b1, 11'd1364, 1'b0, 1'b0, 1'b1},
      '{9'd0,   1'b0, 1'b1, 11'd1362, 1'b1, 1'b1, 1'b0}
   };

   task automatic run_line(input vec_t t, input int idx);
      int ph, e_hi, e_rf, e_hr, e_jp, prev;
      ph   = (m_acc + m_len) % 8;
      m_acc = ph;
      m_len = int'(t.len);
      e_hi = (t.v == 0) ? (t.r2 ? 12 + ph : 20 - ph) : -1;
      e_rf = t.r2 ? 538 - ph : 530;
      e_hr = (int'(t.v) <= (t.os ? 239 : 224)) ? 1104 : -1;
      e_jp = (t.joy && int'(t.v) == (t.os ? 242 : 227)) ? 0 : -1;
      clear_obs();
      prev = -1;
      for (int h = 0; h < int'(t.len); h++) begin
         int reps;
         reps = (t.stall && h == 1104) ? 3 : 1;
         for (int k = 0; k < reps; k++) begin
            @(negedge clk);
            if (prev >= 0) observe(prev);
            if (h == 0) begin
               vcount = t.v; overscan = t.os; rev2 = t.r2;
               joy_auto_en = t.joy; line_len = t.len;
            end
            if (t.flip && h == 300 && k == 0) begin
               vcount = ~vcount; overscan = ~overscan;
               rev2 = ~rev2; joy_auto_en = ~joy_auto_en;
            end
            hcount = 11'(h);
            prev = h;
         end
      end
      @(negedge clk);
      observe(prev);
      // R1 and R2: phase across the line with accumulated length
      chk(ph_bad == 0, "R1/R2", $sformatf("line %0d phase mismatches", idx), ph_bad, 0);
      chk(n_hi == (e_hi >= 0 ? 1 : 0), t.flip ? "R3/R8" : "R3",
          $sformatf("line %0d init count", idx), n_hi, e_hi >= 0 ? 1 : 0);
      if (e_hi >= 0)
         chk(p_hi == e_hi, "R3", $sformatf("line %0d init pos", idx), p_hi, e_hi);
      chk(n_rf == 1 && p_rf == e_rf, t.flip ? "R4/R8" : "R4",
          $sformatf("line %0d refresh pos", idx), p_rf, e_rf);
      chk(n_hr == (e_hr >= 0 ? 1 : 0), t.stall ? "R5/R7" : "R5",
          $sformatf("line %0d run count", idx), n_hr, e_hr >= 0 ? 1 : 0);
      if (e_hr >= 0)
         chk(p_hr == e_hr, "R5", $sformatf("line %0d run pos", idx), p_hr, e_hr);
      chk(n_jp == (e_jp >= 0 ? 1 : 0), "R6",
          $sformatf("line %0d poll count", idx), n_jp, e_jp >= 0 ? 1 : 0);
      if (e_jp >= 0)
         chk(p_jp == 0, "R6", $sformatf("line %0d poll pos", idx), p_jp, 0);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

   initial begin
      int prev;
      // R9: reset state
      rst_n = 0; hcount = 11'd5; vcount = '0; overscan = 0; rev2 = 1;
      line_len = 11'd1364; joy_auto_en = 0;
      m_acc = 0; m_len = 1364;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk({ev_hdma_init, ev_refresh, ev_hdma_run, ev_joy_poll} == 4'b0, "R9",
          "strobes after reset", int'({ev_hdma_init, ev_refresh, ev_hdma_run, ev_joy_poll}), 0);
      chk(dma_phase == 3'd5, "R9", "phase after reset", int'(dma_phase), 5);

      // R4: refresh armed at reset position for revision 2
      clear_obs();
      prev = -1;
      for (int h = 520; h <= 545; h++) begin
         @(negedge clk);
         if (prev >= 0) observe(prev);
         hcount = 11'(h);
         prev = h;
      end
      @(negedge clk);
      observe(prev);
      chk(n_rf == 1 && p_rf == 538, "R4", "refresh at reset position", p_rf, 538);

      // Vector table of whole lines
      for (int i = 0; i < NV; i++) run_line(VECS[i], i);

      // R9: reset in mid-line discards the armed init event
      clear_obs();
      @(negedge clk);
      vcount = '0; rev2 = 0; overscan = 0; hcount = 11'd0;
      for (int h = 1; h <= 5; h++) begin
         @(negedge clk);
         hcount = 11'(h);
      end
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      m_acc = 0; m_len = 1364;
      @(negedge clk);
      chk(dma_phase == 3'd5, "R9", "phase cleared by mid-line reset", int'(dma_phase), 5);
      prev = 5;
      for (int h = 6; h <= 40; h++) begin
         @(negedge clk);
         observe(prev);
         hcount = 11'(h);
         prev = h;
      end
      @(negedge clk);
      observe(prev);
      chk(n_hi == 0, "R9", "init dropped by reset", n_hi, 0);
      chk(ph_bad == 0, "R9", "phase after mid-line reset", ph_bad, 0);

      summary();
   end

endmodule